// File: doc/BRIEF.md
# Receive Frame Buffer Packer

The packer accepts one incoming Ethernet frame at a time as a byte stream and lays it out in a 2 KB buffer page. Each byte goes to the page through a single-byte memory write port, so the receive path needs no intermediate frame store. The host names the target page and the frame length together with the first byte. The packer then writes the frame body as the bytes arrive. When the stream ends it fills in zero padding, an optional CRC-32, a four-byte header and a two-byte trailer.

A page has this layout. Offset 0 holds a 16-bit status word and offset 2 holds a 16-bit stored byte count, both low byte first. The frame body starts at offset 4. Short frames are padded to 64 bytes. The CRC follows the body when it is kept. The page ends with a trailer word made of a data byte and a control byte, and the control byte is the last write of every frame.

When a frame cannot be stored, the packer writes nothing and gives a drop pulse. This happens when receive is disabled, when a soft reset is held, or when the stored byte count would not fit in a page. A done pulse marks a completed page. Allocating the page and raising interrupts are left to the surrounding logic.

Top module: `rx_frame_packer`

## Requirements
- R1: While and right after reset, memWe, frameDone and frameDrop are low.
- R2: The stored byte count at page offsets 2 (low byte) and 3 (high byte) equals B + 6, plus 4 when stripCrc is low. B is 64 for a frame shorter than 64 bytes and the frame length rounded down to even otherwise.
- R3: The status word at offsets 0 (low byte) and 1 (high byte) has bit 11 set when the frame length exceeds 1518 and bit 12 set when the length is odd. All other bits are zero.
- R4: Frame byte i is written at offset 4+i, for every i below B. Cycles with inValid low inside a frame are skipped without effect.
- R5: A frame shorter than 64 bytes keeps its odd last byte in place at offset 4+len-1. Offsets from 4+len up to 67 are written as zero.
- R6: When stripCrc is low, a CRC-32 is written least significant byte first at offsets 4+B to 7+B. It uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. It covers the frame bytes followed by the zero padding.
- R7: A frame of odd length of at least 64 bytes ends with its last byte followed by control byte 0x60. Every other frame ends with 0x00 followed by control byte 0x40.
- R8: When stripCrc is high, no CRC is written and the trailer starts directly at offset 4+B.
- R9: A frame is rejected when rxEnable is low, when softReset is high, or when its stored byte count would exceed 2048. A rejected frame produces no memory write and one frameDrop pulse in the cycle after its first byte.
- R10: An accepted frame performs exactly as many writes as its stored byte count. Every write carries the pageNum value sampled with the first byte.
- R11: frameDone is a one-cycle pulse in the cycle after the write of the control byte, and that write is the frame's last.
- R12: The packer ignores inStart while it is still busy with a frame. It ignores bytes that arrive while it is idle without inStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receive enable; frames are rejected when low |
| softReset | input | 1 | Soft reset level; frames are rejected when high |
| stripCrc | input | 1 | High: do not store a CRC |
| pageNum | input | PAGE_W (2) | Target page, sampled with the first byte |
| frmLen | input | LEN_W (16) | Frame length in bytes, valid with the first byte |
| inValid | input | 1 | Byte strobe |
| inStart | input | 1 | Marks the first byte of a frame |
| inEnd | input | 1 | Marks the last byte of a frame |
| inData | input | 8 | Frame byte |
| memWe | output | 1 | Page memory write enable |
| memPage | output | PAGE_W (2) | Page of the write |
| memAddr | output | ADDR_W (11) | Byte offset within the page |
| memData | output | 8 | Byte written |
| frameDone | output | 1 | Pulse after a frame's page is complete |
| frameDrop | output | 1 | Pulse for a rejected frame |

## Verification
The assertions assume a clean input stream. inStart and inEnd come only with inValid, frmLen is at least 1, and inEnd comes exactly on byte number frmLen. The bench builds every frame from one length value, so its strobes always agree with frmLen. The bench varies gaps, odd and even lengths and the size boundary around 2048. It places a start marker mid-frame and starts a second frame while the first is still being finished, and it checks the whole page image and the write count against its own model.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [2:0] {
    S_IDLE, S_DATA, S_SKIP, S_PAD, S_CRC, S_HEAD, S_TAIL
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       dataWe;
    logic       padWe;
    logic       crcWe;
    logic       headWe;
    logic       tailWe;
    logic [1:0] sub;
  } ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic reject;
    logic padDone;
    logic keepCrc;
  } stat_t;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxp_control.sv
module rxp_control
  import rxp_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  input  logic  inStart,
  input  logic  inEnd,
  input  stat_t stat,
  output ctl_t  ctl,
  output logic  frameDrop
);

  state_t     state, stateD;
  logic [1:0] subQ, subD;

  always_comb begin
    ctl     = '0;
    ctl.sub = subQ;
    stateD  = state;
    subD    = subQ;
    case (state)
      S_IDLE: begin
        if (inValid && inStart) begin
          if (stat.reject) begin
            stateD = inEnd ? S_IDLE : S_SKIP;
          end else begin
            ctl.load   = 1'b1;
            ctl.dataWe = 1'b1;
            stateD     = inEnd ? S_PAD : S_DATA;
          end
        end
      end
      S_DATA: begin
        if (inValid) begin
          ctl.dataWe = 1'b1;
          if (inEnd) stateD = S_PAD;
        end
      end
      S_SKIP: begin
        if (inValid && inEnd) stateD = S_IDLE;
      end
      S_PAD: begin
        if (!stat.padDone) begin
          ctl.padWe = 1'b1;
        end else begin
          stateD = stat.keepCrc ? S_CRC : S_HEAD;
          subD   = 2'd0;
        end
      end
      S_CRC: begin
        ctl.crcWe = 1'b1;
        subD      = subQ + 2'd1;
        if (subQ == 2'd3) stateD = S_HEAD;
      end
      S_HEAD: begin
        ctl.headWe = 1'b1;
        subD       = subQ + 2'd1;
        if (subQ == 2'd3) stateD = S_TAIL;
      end
      S_TAIL: begin
        ctl.tailWe = 1'b1;
        if (subQ == 2'd1) begin
          stateD = S_IDLE;
          subD   = 2'd0;
        end else begin
          subD = subQ + 2'd1;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      subQ      <= 2'd0;
      frameDrop <= 1'b0;
    end else begin
      state     <= stateD;
      subQ      <= subD;
      frameDrop <= (state == S_IDLE) && inValid && inStart && stat.reject;
    end
  end

endmodule

// File: rtl/rxp_datapath.sv
module rxp_datapath
  import rxp_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int PAGE_W     = 2,
  parameter int LEN_W      = 16,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctl_t                            ctl,
  input  logic                            rxEnable,
  input  logic                            softReset,
  input  logic                            stripCrc,
  input  logic [PAGE_W-1:0]               pageNum,
  input  logic [LEN_W-1:0]                frmLen,
  input  logic [7:0]                      inData,
  output stat_t                           stat,
  output logic                            memWe,
  output logic [PAGE_W-1:0]               memPage,
  output logic [$clog2(PAGE_BYTES)-1:0]   memAddr,
  output logic [7:0]                      memData,
  output logic                            frameDone
);

  localparam int ADDR_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = LEN_W + 1;
  localparam logic [LEN_W-1:0]  MIN_L  = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0]  LONG_L = LEN_W'(LONG_LIMIT);
  localparam logic [ADDR_W-1:0] HDR_A  = ADDR_W'(4);

  // frame parameters latched with the first byte
  logic [LEN_W-1:0]  lenQ, idxQ;
  logic              keepQ, longQ, oddLenQ, tailOddQ;
  logic [PAGE_W-1:0] pageQ;
  logic [ADDR_W-1:0] bodyQ;
  logic [15:0]       countQ;
  logic [31:0]       crcQ;
  logic [7:0]        oddQ;
  logic              lastQ;

  // start-time sizing
  logic [CNT_W-1:0]  bodyStart, countStart;
  always_comb begin
    bodyStart  = (frmLen < MIN_L) ? CNT_W'(MIN_FRAME) : {1'b0, frmLen[LEN_W-1:1], 1'b0};
    countStart = bodyStart + CNT_W'(6) + (stripCrc ? CNT_W'(0) : CNT_W'(4));
  end

  assign stat.reject  = !rxEnable || softReset || (countStart > CNT_W'(PAGE_BYTES));
  assign stat.padDone = (idxQ >= MIN_L);
  assign stat.keepCrc = keepQ;

  // write selection
  logic [LEN_W-1:0]  lenEff, idxEff;
  logic [31:0]       crcIn, crcOut;
  logic              skipByte, weD, lastD;
  logic [ADDR_W-1:0] addrD, tailBase;
  logic [7:0]        dataD, crcSel, headSel;

  always_comb begin
    lenEff   = ctl.load ? frmLen : lenQ;
    idxEff   = ctl.load ? '0 : idxQ;
    crcIn    = ctl.load ? 32'hFFFF_FFFF : crcQ;
    crcOut   = ~crcQ;
    skipByte = (idxEff == lenEff - LEN_W'(1)) && lenEff[0] && !(lenEff < MIN_L);
    tailBase = HDR_A + bodyQ + (keepQ ? ADDR_W'(4) : ADDR_W'(0));

    case (ctl.sub)
      2'd0:    crcSel = crcOut[7:0];
      2'd1:    crcSel = crcOut[15:8];
      2'd2:    crcSel = crcOut[23:16];
      default: crcSel = crcOut[31:24];
    endcase
    case (ctl.sub)
      2'd0:    headSel = 8'h00;
      2'd1:    headSel = {3'b000, oddLenQ, longQ, 3'b000};
      2'd2:    headSel = countQ[7:0];
      default: headSel = countQ[15:8];
    endcase

    weD   = 1'b0;
    lastD = 1'b0;
    addrD = '0;
    dataD = 8'h00;
    if (ctl.dataWe) begin
      weD   = !skipByte;
      addrD = HDR_A + idxEff[ADDR_W-1:0];
      dataD = inData;
    end else if (ctl.padWe) begin
      weD   = 1'b1;
      addrD = HDR_A + idxQ[ADDR_W-1:0];
    end else if (ctl.crcWe) begin
      weD   = 1'b1;
      addrD = HDR_A + bodyQ + ADDR_W'(ctl.sub);
      dataD = crcSel;
    end else if (ctl.headWe) begin
      weD   = 1'b1;
      addrD = ADDR_W'(ctl.sub);
      dataD = headSel;
    end else if (ctl.tailWe) begin
      weD   = 1'b1;
      addrD = tailBase + ADDR_W'(ctl.sub);
      if (ctl.sub == 2'd0) dataD = tailOddQ ? oddQ : 8'h00;
      else                 dataD = tailOddQ ? 8'h60 : 8'h40;
      lastD = (ctl.sub == 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ      <= '0;
      idxQ      <= '0;
      keepQ     <= 1'b0;
      longQ     <= 1'b0;
      oddLenQ   <= 1'b0;
      tailOddQ  <= 1'b0;
      pageQ     <= '0;
      bodyQ     <= '0;
      countQ    <= '0;
      crcQ      <= '1;
      oddQ      <= 8'h00;
      lastQ     <= 1'b0;
      memWe     <= 1'b0;
      memPage   <= '0;
      memAddr   <= '0;
      memData   <= 8'h00;
      frameDone <= 1'b0;
    end else begin
      if (ctl.load) begin
        lenQ     <= frmLen;
        keepQ    <= !stripCrc;
        longQ    <= frmLen > LONG_L;
        oddLenQ  <= frmLen[0];
        tailOddQ <= frmLen[0] && !(frmLen < MIN_L);
        pageQ    <= pageNum;
        bodyQ    <= bodyStart[ADDR_W-1:0];
        countQ   <= countStart[15:0];
      end
      if (ctl.dataWe) begin
        crcQ <= crcByte(crcIn, inData);
        idxQ <= idxEff + LEN_W'(1);
        oddQ <= inData;
      end else if (ctl.padWe) begin
        crcQ <= crcByte(crcQ, 8'h00);
        idxQ <= idxQ + LEN_W'(1);
      end
      memWe     <= weD;
      memPage   <= ctl.load ? pageNum : pageQ;
      memAddr   <= addrD;
      memData   <= dataD;
      lastQ     <= lastD;
      frameDone <= lastQ;
    end
  end

endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
  import rxp_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int NUM_PAGES  = 4,
  parameter int LEN_W      = 16,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518,
  localparam int PAGE_W    = $clog2(NUM_PAGES),
  localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              softReset,
  input  logic              stripCrc,
  input  logic [PAGE_W-1:0] pageNum,
  input  logic [LEN_W-1:0]  frmLen,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inEnd,
  input  logic [7:0]        inData,
  output logic              memWe,
  output logic [PAGE_W-1:0] memPage,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              frameDone,
  output logic              frameDrop
);

  ctl_t  ctl;
  stat_t stat;

  rxp_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inStart   (inStart),
    .inEnd     (inEnd),
    .stat      (stat),
    .ctl       (ctl),
    .frameDrop (frameDrop)
  );

  rxp_datapath #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_W     (PAGE_W),
    .LEN_W      (LEN_W),
    .MIN_FRAME  (MIN_FRAME),
    .LONG_LIMIT (LONG_LIMIT)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .rxEnable  (rxEnable),
    .softReset (softReset),
    .stripCrc  (stripCrc),
    .pageNum   (pageNum),
    .frmLen    (frmLen),
    .inData    (inData),
    .stat      (stat),
    .memWe     (memWe),
    .memPage   (memPage),
    .memAddr   (memAddr),
    .memData   (memData),
    .frameDone (frameDone)
  );

endmodule

// File: rtl/rxp_checker.sv
module rxp_checker #(
  parameter int PAGE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWe,
  input logic [PAGE_W-1:0] memPage,
  input logic [7:0]        memData,
  input logic              frameDone,
  input logic              frameDrop
);

  // R11: done lasts a single cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R11: done directly follows the control byte write
  assert_done_after_ctl_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> ($past(memWe) && ($past(memData) == 8'h40 || $past(memData) == 8'h60)));

  // R9: a rejected frame writes nothing and completes nothing
  assert_drop_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameDrop |-> (!memWe && !frameDone));

  // R10: back-to-back writes of one frame keep the page
  assert_page_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe) && !frameDone) |-> $stable(memPage));

endmodule

bind rx_frame_packer rxp_checker #(.PAGE_W(PAGE_W)) u_rxp_checker (
  .clk       (clk),
  .rstN      (rstN),
  .memWe     (memWe),
  .memPage   (memPage),
  .memData   (memData),
  .frameDone (frameDone),
  .frameDrop (frameDrop)
);

// File: tb/test_rx_frame_packer.sv
module test_rx_frame_packer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxEnable = 1'b1, softReset = 1'b0, stripCrc = 1'b0;
  logic [1:0]  pageNum = '0;
  logic [15:0] frmLen = '0;
  logic        inValid = 1'b0, inStart = 1'b0, inEnd = 1'b0;
  logic [7:0]  inData = '0;
  logic        memWe, memPage0, frameDone, frameDrop;
  logic [1:0]  memPage;
  logic [10:0] memAddr;
  logic [7:0]  memData;

  int checks = 0, failures = 0;
  int wrCount, doneCount, dropCount, pageErr, doneAddr;
  bit doneAfterWe;
  logic [1:0] curPage;
  logic [7:0] img [0:2047];
  logic [7:0] frm [0:2047];
  logic       prevWe;
  logic [10:0] prevAddr;

  always #5 clk = ~clk;

  rx_frame_packer i_rx_frame_packer (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .softReset(softReset),
    .stripCrc(stripCrc), .pageNum(pageNum), .frmLen(frmLen),
    .inValid(inValid), .inStart(inStart), .inEnd(inEnd), .inData(inData),
    .memWe(memWe), .memPage(memPage), .memAddr(memAddr), .memData(memData),
    .frameDone(frameDone), .frameDrop(frameDrop)
  );
  assign memPage0 = memPage[0];

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (frameDone) begin
      doneCount++;
      doneAfterWe = prevWe;
      doneAddr    = prevAddr;
    end
    if (frameDrop) dropCount++;
    if (memWe) begin
      img[memAddr] = memData;
      wrCount++;
      if (memPage != curPage) pageErr++;
    end
    prevWe   = memWe;
    prevAddr = memAddr;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrc(input int len);
    logic [31:0] c;
    int n;
    c = 32'hFFFF_FFFF;
    n = (len < 64) ? 64 : len;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = (i < len) ? frm[i] : 8'h00;
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    return ~c;
  endfunction

  task automatic prep(input int seed, input logic [1:0] page);
    for (int i = 0; i < 2048; i++) begin
      img[i] = 8'hEE;
      frm[i] = 8'((i * 7 + seed * 13 + (i >> 3)) & 8'hFF);
    end
    wrCount = 0; doneCount = 0; dropCount = 0; pageErr = 0;
    doneAfterWe = 0; doneAddr = -1;
    curPage = page;
  endtask

  task automatic drive(input int len, input logic [1:0] page, input bit strip,
                       input int gap, input bit midStart);
    stripCrc = strip;
    pageNum  = page;
    frmLen   = 16'(len);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inStart = (i == 0) || (midStart && i == len / 2);
      inEnd   = (i == len - 1);
      inData  = frm[i];
      @(negedge clk);
      if (i == 0) pageNum = page ^ 2'b01;
      if (gap != 0 && (i % gap) == gap - 1 && i != len - 1) begin
        inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0; inData = 8'hA5;
        @(negedge clk);
      end
    end
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 400 && doneCount == 0 && dropCount == 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic checkFrame(input string nm, input int len, input bit strip);
    int body, cnt, dErr, pErr, cErr, tOff;
    logic [31:0] c;
    logic [15:0] st;
    logic [7:0]  t0, t1;
    body = (len < 64) ? 64 : (len & ~1);
    cnt  = body + 6 + (strip ? 0 : 4);
    st = '0;
    if (len > 1518) st[11] = 1'b1;
    if (len % 2)    st[12] = 1'b1;
    chk({img[1], img[0]} == st, {"R3 status ", nm}, {img[1], img[0]}, st);
    chk({img[3], img[2]} == 16'(cnt), {"R2 count ", nm}, {img[3], img[2]}, cnt);
    dErr = 0; pErr = 0;
    for (int i = 0; i < body; i++) begin
      if (i < len) begin if (img[4 + i] !== frm[i]) dErr++; end
      else if (img[4 + i] !== 8'h00) pErr++;
    end
    chk(dErr == 0, {"R4 data ", nm}, dErr, 0);
    if (len < 64) chk(pErr == 0, {"R5 pad ", nm}, pErr, 0);
    if (!strip) begin
      c = refCrc(len);
      cErr = 0;
      for (int k = 0; k < 4; k++) if (img[4 + body + k] !== c[8*k +: 8]) cErr++;
      chk(cErr == 0, {"R6 crc ", nm}, {img[7+body], img[6+body], img[5+body], img[4+body]}, c);
    end
    tOff = 4 + body + (strip ? 0 : 4);
    if ((len % 2) && len >= 64) begin t0 = frm[len - 1]; t1 = 8'h60; end
    else begin t0 = 8'h00; t1 = 8'h40; end
    chk(img[tOff] === t0 && img[tOff + 1] === t1, strip ? {"R8 R7 trailer ", nm} : {"R7 trailer ", nm},
        {img[tOff], img[tOff + 1]}, {t0, t1});
    chk(wrCount == cnt && pageErr == 0, {"R10 writes/page ", nm}, wrCount, cnt);
    chk(doneCount == 1 && doneAfterWe && doneAddr == cnt - 1, {"R11 done ", nm}, doneAddr, cnt - 1);
    chk(dropCount == 0, {"R9 no drop ", nm}, dropCount, 0);
  endtask

  task automatic runFrame(input string nm, input int len, input bit strip,
                          input logic [1:0] page, input int seed, input int gap);
    prep(seed, page);
    drive(len, page, strip, gap, 1'b0);
    waitEnd();
    checkFrame(nm, len, strip);
  endtask

  task automatic t_reset();
    chk(!memWe && !frameDone && !frameDrop, "R1 reset outputs", {memWe, frameDone, frameDrop}, 0);
  endtask

  task automatic t_reject(input string nm, input int len, input bit strip, input bit en, input bit sr);
    prep(9, 2'd3);
    rxEnable = en; softReset = sr;
    drive(len, 2'd3, strip, 0, 1'b0);
    waitEnd();
    chk(wrCount == 0 && dropCount == 1 && doneCount == 0, {"R9 reject ", nm}, wrCount, 0);
    rxEnable = 1'b1; softReset = 1'b0;
  endtask

  task automatic t_busy();
    // R12: start marker mid-frame, then a second frame during finishing
    prep(4, 2'd2);
    drive(90, 2'd2, 1'b0, 0, 1'b1);
    drive(3, 2'd1, 1'b0, 0, 1'b0);
    waitEnd();
    checkFrame("R12 busy", 90, 1'b0);
    wrCount = 0;
    for (int i = 0; i < 5; i++) begin
      inValid = 1'b1; inData = 8'h5A; inEnd = (i == 4);
      @(negedge clk);
    end
    inValid = 1'b0; inEnd = 1'b0;
    repeat (5) @(negedge clk);
    chk(wrCount == 0 && doneCount == 1, "R12 idle bytes", wrCount, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    runFrame("even100", 100, 1'b0, 2'd1, 1, 0);
    runFrame("odd101 gaps", 101, 1'b0, 2'd2, 2, 5);
    runFrame("short odd33", 33, 1'b0, 2'd0, 3, 0);
    runFrame("short len1", 1, 1'b1, 2'd3, 5, 0);
    runFrame("short even10 strip", 10, 1'b1, 2'd1, 6, 3);
    runFrame("odd81 strip", 81, 1'b1, 2'd2, 7, 0);
    runFrame("long1601", 1601, 1'b0, 2'd0, 8, 0);
    runFrame("max2039", 2039, 1'b0, 2'd1, 10, 0);
    runFrame("2040 strip", 2040, 1'b1, 2'd2, 11, 0);
    t_reject("oversize", 2040, 1'b0, 1'b1, 1'b0);
    t_reject("disabled", 50, 1'b0, 1'b0, 1'b0);
    t_reject("softreset", 70, 1'b1, 1'b1, 1'b1);
    runFrame("after reject", 64, 1'b0, 2'd3, 12, 0);
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule